// File: doc/BRIEF.md
# Output Fault Supervisor with Power-Good

This block watches a regulator's output in the digital domain. It compares a sensed output-voltage code with the target code, and it also takes an average-current overcurrent flag and a flag that marks the target as a no-CPU code. From these inputs it drives a power-good output. It holds a latched shutdown for severe faults, and for an overvoltage it orders every low-side switch on so that the output is clamped.

All voltage codes use the same scale, with one LSB equal to 5 mV. The overvoltage limit changes with the start-up phase. While soft-start runs, the limit is the larger of a fixed floor (1.280 V) and the target plus 175 mV. Once soft-start is over, the limit is the target plus 175 mV only.

Overvoltage, overcurrent and no-CPU faults latch the supervisor off. The latch can only be released by a fresh low-to-high edge on the enable input, after which an outside sequencer runs soft-start again. Undervoltage is handled differently: it only lowers power-good and does not latch. It trips when the output falls below half the target and releases once the output climbs above that level plus a hysteresis margin. Every pin is a plain level signal, so the block has no stream handshake and no back-pressure.

Top module: `outfault_sup`

## Requirements
- R1: While reset is held and on the first sampled cycle after it, power_ok, fault_hold and low_clamp are 0 and drive_off is 1.
- R2: power_ok goes to 1 one clock after enable, ss_done and ready_dly are all sampled high, provided no undervoltage or latched fault is present. It goes to 0 one clock after any of those three inputs is sampled low.
- R3: While ss_done is 0, an overvoltage is detected when out_code > max(OV_FLOOR, target + OV_MARGIN). With the defaults this is max(256, target + 35).
- R4: While ss_done is 1, an overvoltage is detected when out_code > target + OV_MARGIN, and the fixed floor plays no part.
- R5: An overvoltage sampled while enabled makes fault_hold, low_clamp and drive_off go to 1 on the next clock, with power_ok going to 0 on that same clock.
- R6: over_cur sampled high while enabled latches fault_hold and drive_off on the next clock, but leaves low_clamp at 0.
- R7: no_cpu sampled high while enabled latches fault_hold and drive_off on the next clock, but leaves low_clamp at 0.
- R8: Once latched, all outputs hold their values whatever out_code, over_cur, no_cpu, ss_done or a low enable do. Only a clock at which enable is high after a clock at which it was low clears fault_hold and low_clamp, and they read 0 on the following clock.
- R9: out_code < target/2 (the target shifted right by one), sampled while enabled, drives power_ok to 0 on the next clock and does not set fault_hold.
- R10: After an undervoltage, power_ok stays 0 while out_code stays at or below target/2 + UV_HYST (default 10 codes, which is 50 mV). It goes back to 1 one clock after out_code rises above that level, with no action on enable.
- R11: drive_off is 1 one clock after enable is sampled low, and power_ok is 0 at that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Regulator enable; its rising edge clears a latched fault |
| target | input | CODE_W | Target output code (5 mV per LSB) |
| no_cpu | input | 1 | Target decodes to a no-CPU condition |
| out_code | input | CODE_W | Sensed output code, same scale as target |
| over_cur | input | 1 | Average-current overcurrent flag |
| ss_done | input | 1 | Soft-start has reached the target |
| ready_dly | input | 1 | Fixed ready delay after soft-start has elapsed |
| power_ok | output | 1 | Power-good indication |
| fault_hold | output | 1 | A latching fault is held |
| low_clamp | output | 1 | Command all low-side switches on (overvoltage) |
| drive_off | output | 1 | Switching drives disabled |

## Verification
The overvoltage limit is tried with targets on both sides of the fixed floor, with soft-start both open and closed. Probing just above target + 35 tells the two limit rules apart. Each latching cause is then followed by a return to normal output and by a low enable, which separates the latch from a simple level-following flag, and an overcurrent is checked on its own to show it never asserts the clamp. The undervoltage sequence of trip, a value inside the hysteresis band, and release separates hysteresis from a single comparison. A long seeded random run then mixes enable toggles, target changes, sag and overshoot against a bench model.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
  // Causes that can latch the supervisor off.
  typedef struct packed {
    logic ov;
    logic oc;
    logic ncpu;
  } trip_t;

  function automatic logic any_trip(trip_t t);
    return t.ov | t.oc | t.ncpu;
  endfunction
endpackage

// File: rtl/ofs_thresh.sv
module ofs_thresh #(
  parameter int CODE_W    = 10,
  parameter int OV_FLOOR  = 256,
  parameter int OV_MARGIN = 35,
  parameter int UV_HYST   = 10
) (
  input  logic [CODE_W-1:0] target,
  input  logic              ss_done,
  output logic [CODE_W:0]   ov_lim,
  output logic [CODE_W:0]   uv_trip,
  output logic [CODE_W:0]   uv_rel
);
  localparam int TW = CODE_W + 1;
  localparam logic [TW-1:0] FLOOR_C  = TW'(OV_FLOOR);
  localparam logic [TW-1:0] MARGIN_C = TW'(OV_MARGIN);
  localparam logic [TW-1:0] HYST_C   = TW'(UV_HYST);

  logic [TW-1:0] tgt_ofs;

  always_comb begin
    tgt_ofs = {1'b0, target} + MARGIN_C;
    if (!ss_done && (FLOOR_C > tgt_ofs)) ov_lim = FLOOR_C;
    else                                 ov_lim = tgt_ofs;
    uv_trip = {2'b00, target[CODE_W-1:1]};
    uv_rel  = uv_trip + HYST_C;
  end
endmodule

// File: rtl/ofs_uv_track.sv
module ofs_uv_track #(
  parameter int CODE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [CODE_W-1:0] out_code,
  input  logic [CODE_W:0]   uv_trip,
  input  logic [CODE_W:0]   uv_rel,
  output logic              uv_low
);
  logic [CODE_W:0] v_ext;
  assign v_ext = {1'b0, out_code};

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) uv_low <= 1'b0;
    else if (v_ext < uv_trip) uv_low <= 1'b1;
    else if (v_ext > uv_rel)  uv_low <= 1'b0;
  end
endmodule

// File: rtl/ofs_latch.sv
module ofs_latch
  import ofs_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  enable,
  input  trip_t trip,
  output logic  held,
  output logic  ov_cause,
  output logic  en_q
);
  logic en_rise;
  assign en_rise = enable & ~en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held     <= 1'b0;
      ov_cause <= 1'b0;
      en_q     <= 1'b0;
    end else begin
      en_q <= enable;
      if (en_rise) begin
        held     <= 1'b0;
        ov_cause <= 1'b0;
      end else if (!held && enable && any_trip(trip)) begin
        held     <= 1'b1;
        ov_cause <= trip.ov;
      end
    end
  end
endmodule

// File: rtl/outfault_sup.sv
module outfault_sup
  import ofs_pkg::*;
#(
  parameter int CODE_W    = 10,
  parameter int OV_FLOOR  = 256,
  parameter int OV_MARGIN = 35,
  parameter int UV_HYST   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [CODE_W-1:0] target,
  input  logic              no_cpu,
  input  logic [CODE_W-1:0] out_code,
  input  logic              over_cur,
  input  logic              ss_done,
  input  logic              ready_dly,
  output logic              power_ok,
  output logic              fault_hold,
  output logic              low_clamp,
  output logic              drive_off
);
  logic [CODE_W:0] ov_lim, uv_trip, uv_rel;
  logic            uv_low, held, ov_cause, en_q, rdy_q;
  trip_t           trip;

  ofs_thresh #(
    .CODE_W(CODE_W), .OV_FLOOR(OV_FLOOR),
    .OV_MARGIN(OV_MARGIN), .UV_HYST(UV_HYST)
  ) u_thresh (
    .target(target), .ss_done(ss_done),
    .ov_lim(ov_lim), .uv_trip(uv_trip), .uv_rel(uv_rel)
  );

  ofs_uv_track #(.CODE_W(CODE_W)) u_uv (
    .clk(clk), .rst_n(rst_n), .enable(enable), .out_code(out_code),
    .uv_trip(uv_trip), .uv_rel(uv_rel), .uv_low(uv_low)
  );

  always_comb begin
    trip.ov   = {1'b0, out_code} > ov_lim;
    trip.oc   = over_cur;
    trip.ncpu = no_cpu;
  end

  ofs_latch u_latch (
    .clk(clk), .rst_n(rst_n), .enable(enable), .trip(trip),
    .held(held), .ov_cause(ov_cause), .en_q(en_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= enable & ss_done & ready_dly;
  end

  assign power_ok   = rdy_q & ~uv_low & ~held;
  assign fault_hold = held;
  assign low_clamp  = held & ov_cause;
  assign drive_off  = held | ~en_q;
endmodule

// File: rtl/ofs_checker.sv
module ofs_checker #(
  parameter int CODE_W    = 10,
  parameter int OV_MARGIN = 35
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic [CODE_W-1:0] target,
  input logic              no_cpu,
  input logic [CODE_W-1:0] out_code,
  input logic              over_cur,
  input logic              ss_done,
  input logic              ready_dly,
  input logic              power_ok,
  input logic              fault_hold,
  input logic              low_clamp,
  input logic              drive_off
);
  localparam logic [CODE_W:0] MG = (CODE_W+1)'(OV_MARGIN);

  p_pg_needs_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    power_ok |-> $past(enable && ss_done && ready_dly));

  p_ov_reg_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    enable ##1 (enable && ss_done && ({1'b0, out_code} > ({1'b0, target} + MG)))
    |=> fault_hold);

  p_clamp_with_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    low_clamp |-> (fault_hold && drive_off && !power_ok));

  p_oc_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && over_cur) ##1 (enable && over_cur) |=> fault_hold);

  p_ncpu_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && no_cpu) ##1 (enable && no_cpu) |=> fault_hold);

  p_clear_on_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_hold) |-> ($past(enable) && !$past(enable, 2)));

  p_uv_drops_pg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && ({1'b0, out_code} < {2'b00, target[CODE_W-1:1]})) |=> !power_ok);

  p_off_when_disabled_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (drive_off && !power_ok));
endmodule

bind outfault_sup ofs_checker #(.CODE_W(CODE_W), .OV_MARGIN(OV_MARGIN)) u_ofs_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .target(target), .no_cpu(no_cpu),
  .out_code(out_code), .over_cur(over_cur), .ss_done(ss_done), .ready_dly(ready_dly),
  .power_ok(power_ok), .fault_hold(fault_hold), .low_clamp(low_clamp),
  .drive_off(drive_off)
);

// File: tb/outfault_sup_bench.sv
module outfault_sup_bench;
  localparam int CLK_P = 10;
  localparam int W = 10;
  localparam int FLOOR = 256, MARGIN = 35, HYST = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, no_cpu = 1'b0, over_cur = 1'b0, ss_done = 1'b0, ready_dly = 1'b0;
  logic [W-1:0] target = 10'd200, out_code = 10'd0;
  logic power_ok, fault_hold, low_clamp, drive_off;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // bench model state, written from the requirements
  logic m_lat, m_ovc, m_uv, m_rdy, m_en;

  always #(CLK_P/2) clk = ~clk;

  outfault_sup #(.CODE_W(W), .OV_FLOOR(FLOOR), .OV_MARGIN(MARGIN), .UV_HYST(HYST))
  u_outfault_sup (
    .clk(clk), .rst_n(rst_n), .enable(enable), .target(target), .no_cpu(no_cpu),
    .out_code(out_code), .over_cur(over_cur), .ss_done(ss_done), .ready_dly(ready_dly),
    .power_ok(power_ok), .fault_hold(fault_hold), .low_clamp(low_clamp),
    .drive_off(drive_off)
  );

  function automatic int ov_limit(int tgt, bit ss);
    int a = tgt + MARGIN;
    if (!ss && FLOOR > a) return FLOOR;
    return a;
  endfunction

  task automatic model_step();
    int  lim;
    bit  ov, rise;
    if (!rst_n) begin
      m_lat = 0; m_ovc = 0; m_uv = 0; m_rdy = 0; m_en = 0;
      return;
    end
    lim  = ov_limit(int'(target), ss_done);
    ov   = int'(out_code) > lim;
    rise = enable && !m_en;
    if (rise) begin m_lat = 0; m_ovc = 0; end
    else if (!m_lat && enable && (ov || over_cur || no_cpu)) begin m_lat = 1; m_ovc = ov; end
    if (!enable) m_uv = 0;
    else if (int'(out_code) < int'(target) / 2) m_uv = 1;
    else if (int'(out_code) > int'(target) / 2 + HYST) m_uv = 0;
    m_rdy = enable && ss_done && ready_dly;
    m_en  = enable;
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_model(string where);
    chk({where, " R2 R9 R10 power_ok"}, power_ok, m_rdy && !m_uv && !m_lat);
    chk({where, " R5 R6 R7 R8 fault_hold"}, fault_hold, m_lat);
    chk({where, " R5 R6 R8 low_clamp"}, low_clamp, m_lat && m_ovc);
    chk({where, " R11 drive_off"}, drive_off, m_lat || !m_en);
  endtask

  // return to a clean, enabled, regulating state
  task automatic restart(int tgt);
    enable = 0; over_cur = 0; no_cpu = 0; ss_done = 0; ready_dly = 0;
    target = W'(tgt); out_code = W'(tgt);
    tick();
    enable = 1; tick();
    ss_done = 1; ready_dly = 1; tick();
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk + 1, n_bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd7215);
    // R1 reset state
    tick(); tick();
    chk("R1 power_ok", power_ok, 1'b0);
    chk("R1 fault_hold", fault_hold, 1'b0);
    chk("R1 low_clamp", low_clamp, 1'b0);
    chk("R1 drive_off", drive_off, 1'b1);
    rst_n = 1; tick();
    chk("R1 first cycle drive_off", drive_off, 1'b1);
    chk("R1 first cycle power_ok", power_ok, 1'b0);

    // R2 ready gating
    target = 10'd200; out_code = 10'd200; enable = 1; tick();
    chk("R2 no ss power_ok", power_ok, 1'b0);
    chk("R11 enabled drive_off", drive_off, 1'b0);
    ss_done = 1; tick();
    chk("R2 ss without delay power_ok", power_ok, 1'b0);
    ready_dly = 1; tick();
    chk("R2 ready power_ok", power_ok, 1'b1);

    // R3 floor applies during soft-start: limit max(256,235)=256
    ss_done = 0; ready_dly = 0; out_code = 10'd240; tick();
    chk("R3 240 below floor fault_hold", fault_hold, 1'b0);
    out_code = 10'd256; tick();
    chk("R3 256 at floor fault_hold", fault_hold, 1'b0);
    out_code = 10'd257; tick();
    chk("R3 257 above floor fault_hold", fault_hold, 1'b1);
    chk("R5 clamp from ss ov", low_clamp, 1'b1);

    // R3 target above floor during soft-start: limit 275
    restart(240); ss_done = 0; ready_dly = 0; out_code = 10'd270; tick();
    chk("R3 high target 270 fault_hold", fault_hold, 1'b0);
    out_code = 10'd276; tick();
    chk("R3 high target 276 fault_hold", fault_hold, 1'b1);

    // R4 regulation uses target+35 only: 236 trips for target 200
    restart(200); out_code = 10'd235; tick();
    chk("R4 235 no trip", fault_hold, 1'b0);
    chk("R2 still good", power_ok, 1'b1);
    out_code = 10'd236; tick();
    chk("R4 236 trips", fault_hold, 1'b1);
    chk("R5 low_clamp", low_clamp, 1'b1);
    chk("R5 drive_off", drive_off, 1'b1);
    chk("R5 power_ok low", power_ok, 1'b0);

    // R8 latched: normal output, low enable do not clear
    out_code = 10'd200; tick(); tick();
    chk("R8 back to normal fault_hold", fault_hold, 1'b1);
    chk("R8 back to normal power_ok", power_ok, 1'b0);
    enable = 0; tick();
    chk("R8 enable low fault_hold", fault_hold, 1'b1);
    chk("R8 enable low low_clamp", low_clamp, 1'b1);
    chk("R11 enable low drive_off", drive_off, 1'b1);
    enable = 1; tick();
    chk("R8 rise clears fault_hold", fault_hold, 1'b0);
    chk("R8 rise clears low_clamp", low_clamp, 1'b0);
    tick();
    chk("R2 good after re-enable", power_ok, 1'b1);

    // R6 overcurrent
    over_cur = 1; tick(); over_cur = 0;
    chk("R6 fault_hold", fault_hold, 1'b1);
    chk("R6 low_clamp stays 0", low_clamp, 1'b0);
    chk("R6 drive_off", drive_off, 1'b1);
    tick();
    chk("R8 oc held after flag drops", fault_hold, 1'b1);

    // R7 no-CPU code
    restart(200); no_cpu = 1; tick(); no_cpu = 0;
    chk("R7 fault_hold", fault_hold, 1'b1);
    chk("R7 low_clamp stays 0", low_clamp, 1'b0);
    chk("R7 power_ok", power_ok, 1'b0);

    // R9 / R10 undervoltage with hysteresis: trip <100, release >110
    restart(200);
    out_code = 10'd100; tick();
    chk("R9 100 not below trip", power_ok, 1'b1);
    out_code = 10'd99; tick();
    chk("R9 99 pulls power_ok", power_ok, 1'b0);
    chk("R9 no latch", fault_hold, 1'b0);
    out_code = 10'd105; tick();
    chk("R10 inside band", power_ok, 1'b0);
    out_code = 10'd110; tick();
    chk("R10 at release level", power_ok, 1'b0);
    out_code = 10'd111; tick();
    chk("R10 released", power_ok, 1'b1);

    // R11 enable low
    enable = 0; tick();
    chk("R11 drive_off", drive_off, 1'b1);
    chk("R11 power_ok", power_ok, 1'b0);

    // seeded random run against bench model
    restart(200);
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom_range(999));
      if (r < 6) enable = ~enable;
      else if (r < 12) target = W'($urandom_range(300, 100));
      if ($urandom_range(39) == 0) ss_done = ~ss_done;
      if ($urandom_range(29) == 0) ready_dly = ~ready_dly;
      over_cur = ($urandom_range(399) == 0);
      no_cpu   = ($urandom_range(599) == 0);
      r = int'($urandom_range(99));
      if (r < 4)       out_code = W'($urandom_range(int'(target) / 2 + 15));
      else if (r < 7)  out_code = W'(int'(target) + int'($urandom_range(90, 20)));
      else             out_code = W'(int'(target) - 10 + int'($urandom_range(30)));
      tick();
      chk_model("random");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule